// File: doc/BRIEF.md
# Leading Position One-Hot Encoder

This combinational block receives an N-bit indicator vector in which the most significant set bit marks where the leading digit of a result sits. From it the block forms three views of that position. The first is a thermometer string that is low above the first indicator and high from that indicator downward. The second is a one-hot vector with a single line high at the first indicator. The third is a binary shift amount equal to the number of indicator bits that precede the first set one.

Each bit of the shift amount is a flat OR over the one-hot lines whose position index has that bit set, with no multiplexer tree in between. A normaliser can therefore take the one-hot vector or the thermometer string for its last shift stage and the binary count for its early stages, all from one encoder. A zero flag reports an indicator vector with no bit set. The block has no clock; its outputs follow its input after the logic settles.

Top module: `lpe_leading_encoder`

## Requirements
- R1: The width N is a power of two and the shift amount is log2(N) bits wide.
- R2: Input bit N-1 is position 0, the most significant; in every output vector, position p sits at bit N-1-p.
- R3: The thermometer output is high at position p exactly when some indicator at position p or at a more significant position is set, so its bits form a run of zeros followed by a run of ones when read from bit N-1 down to bit 0.
- R4: When any indicator is set, exactly one one-hot line is high, at the most significant set indicator; position 0 has no line above it and is marked whenever its own indicator is set.
- R5: The shift amount equals the position index of the first set indicator, which is the count of zero bits above it in the input.
- R6: Shift-amount bit b is the OR of the one-hot lines at positions whose index has bit b set; for N = 8 the top count bit is the OR of positions 4, 5, 6 and 7.
- R7: An all-zero input gives an all-zero thermometer string, an all-zero one-hot vector, a zero shift amount and a high zero flag.
- R8: Indicator bits less significant than the first set one change none of the outputs.
- R9: The zero flag is low whenever any indicator bit is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ind_i | input | N | Indicator vector, bit N-1 is position 0 |
| therm_o | output | N | Prefix-OR thermometer string |
| hot_o | output | N | One-hot mark of the first set indicator |
| shamt_o | output | log2(N) | Binary position of the first set indicator |
| none_o | output | 1 | High when no indicator bit is set |

## Verification
The assertions watch, whenever the input changes, that the thermometer string has the shape of a single run of ones, that it covers every set indicator, that the one-hot vector has at most one line high and only on a set indicator, that the line selected by the shift amount is the one that is high, and that the zero flag agrees with the input. That the marked line is the most significant one, that lower bits have no effect, and that each count bit collects the right group of lines are shown by the bench scenarios: walking single bits, every leading position with varied low-order noise, the all-ones and all-zero vectors, and a group-by-group check of the count bits against the one-hot lines.

// File: rtl/lpe_pkg.sv
package lpe_pkg;

  // True when n is a nonzero power of two.
  function automatic bit lpe_is_pow2(input int unsigned n);
    return (n != 0) && ((n & (n - 1)) == 0);
  endfunction

  // True when position index p has bit b set.
  function automatic bit lpe_pos_has_bit(input int unsigned p, input int unsigned b);
    return ((p >> b) & 1) == 1;
  endfunction

endpackage

// File: rtl/lpe_prefix_or.sv
// Log-depth prefix OR over position order (index 0 = most significant).
module lpe_prefix_or #(
  parameter int N = 32
) (
  input  logic [N-1:0] pos_i,
  output logic [N-1:0] pre_o
);
  localparam int LG = $clog2(N);

  logic [LG:0][N-1:0] stg;

  assign stg[0] = pos_i;

  for (genvar s = 0; s < LG; s++) begin : g_lvl
    localparam int DIST = 1 << s;
    for (genvar p = 0; p < N; p++) begin : g_pos
      if (p >= DIST) begin : g_join
        assign stg[s+1][p] = stg[s][p] | stg[s][p-DIST];
      end else begin : g_pass
        assign stg[s+1][p] = stg[s][p];
      end
    end
  end

  assign pre_o = stg[LG];
endmodule

// File: rtl/lpe_first_mark.sv
// Marks the first set indicator: own bit AND NOT prefix of the position above.
module lpe_first_mark #(
  parameter int N = 32
) (
  input  logic [N-1:0] pos_i,
  input  logic [N-1:0] pre_i,
  output logic [N-1:0] hot_o
);
  for (genvar p = 0; p < N; p++) begin : g_mark
    if (p == 0) begin : g_top
      assign hot_o[p] = pos_i[p];
    end else begin : g_rest
      assign hot_o[p] = pos_i[p] & ~pre_i[p-1];
    end
  end
endmodule

// File: rtl/lpe_count_or.sv
// Each count bit is a flat OR of the one-hot lines whose index carries that bit.
module lpe_count_or
  import lpe_pkg::*;
#(
  parameter int N = 32,
  localparam int CW = $clog2(N)
) (
  input  logic [N-1:0]  hot_i,
  output logic [CW-1:0] cnt_o
);
  for (genvar b = 0; b < CW; b++) begin : g_plane
    logic [N-1:0] sel;
    for (genvar p = 0; p < N; p++) begin : g_sel
      if (lpe_pos_has_bit(p, b)) begin : g_on
        assign sel[p] = hot_i[p];
      end else begin : g_off
        assign sel[p] = 1'b0;
      end
    end
    assign cnt_o[b] = |sel;
  end
endmodule

// File: rtl/lpe_leading_encoder.sv
module lpe_leading_encoder #(
  parameter int N = 32,
  localparam int CW = $clog2(N)
) (
  input  logic [N-1:0]  ind_i,
  output logic [N-1:0]  therm_o,
  output logic [N-1:0]  hot_o,
  output logic [CW-1:0] shamt_o,
  output logic          none_o
);
  logic [N-1:0] pos_in;
  logic [N-1:0] pos_pre;
  logic [N-1:0] pos_hot;

  // Swizzle between bit order and position order (position 0 = bit N-1).
  for (genvar p = 0; p < N; p++) begin : g_swz
    assign pos_in[p]      = ind_i[N-1-p];
    assign therm_o[N-1-p] = pos_pre[p];
    assign hot_o[N-1-p]   = pos_hot[p];
  end

  lpe_prefix_or #(.N(N)) u_pre (
    .pos_i (pos_in),
    .pre_o (pos_pre)
  );

  lpe_first_mark #(.N(N)) u_mark (
    .pos_i (pos_in),
    .pre_i (pos_pre),
    .hot_o (pos_hot)
  );

  lpe_count_or #(.N(N)) u_cnt (
    .hot_i (pos_hot),
    .cnt_o (shamt_o)
  );

  assign none_o = ~pos_pre[N-1];
endmodule

// File: rtl/lpe_leading_encoder_chk.sv
module lpe_leading_encoder_chk
  import lpe_pkg::*;
#(
  parameter int N = 32,
  localparam int CW = $clog2(N)
) (
  input logic [N-1:0]  ind_i,
  input logic [N-1:0]  therm_o,
  input logic [N-1:0]  hot_o,
  input logic [CW-1:0] shamt_o,
  input logic          none_o
);
  initial begin
    a_r1_width_pow2: assert (lpe_is_pow2(N)) else $error("R1 width not a power of two");
  end

  always_comb begin
    // R3: thermometer is a single low-order run of ones
    a_r3_single_run: assert (((therm_o + 1'b1) & therm_o) == '0)
      else $error("R3 thermometer not monotonic");
    // R3: every set indicator lies inside the run
    a_r3_covers: assert ((ind_i & ~therm_o) == '0)
      else $error("R3 indicator outside thermometer");
    // R4: at most one line high, and only on a set indicator
    a_r4_onehot0: assert ($onehot0(hot_o)) else $error("R4 more than one line");
    a_r4_on_ind: assert ((hot_o & ~ind_i) == '0) else $error("R4 mark on clear bit");
    a_r4_present: assert ((ind_i == '0) || ($countones(hot_o) == 1))
      else $error("R4 no mark for nonzero input");
    // R5: the count selects the marked line
    a_r5_cnt_sel: assert ((hot_o == '0) || hot_o[N-1-int'(shamt_o)])
      else $error("R5 count does not select mark");
    // R7 / R9: zero flag agrees with the input
    a_r7_zero_out: assert (!none_o || (hot_o == '0 && shamt_o == '0 && therm_o == '0))
      else $error("R7 outputs not clear on zero");
    a_r9_flag: assert (none_o == (ind_i == '0)) else $error("R9 zero flag wrong");
  end
endmodule

bind lpe_leading_encoder lpe_leading_encoder_chk #(.N(N)) u_chk (
  .ind_i   (ind_i),
  .therm_o (therm_o),
  .hot_o   (hot_o),
  .shamt_o (shamt_o),
  .none_o  (none_o)
);

// File: tb/sim_lpe_leading_encoder.sv
`timescale 1ns/1ps
module sim_lpe_leading_encoder;
  localparam int N  = 32;
  localparam int CW = $clog2(N);

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [N-1:0]  ind;
  logic [N-1:0]  therm;
  logic [N-1:0]  hot;
  logic [CW-1:0] shamt;
  logic          none;

  lpe_leading_encoder #(.N(N)) u0 (
    .ind_i (ind), .therm_o (therm), .hot_o (hot), .shamt_o (shamt), .none_o (none)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [31:0] rng = 32'h1357_9bdf;

  logic [N-1:0]  e_therm, e_hot;
  logic [CW-1:0] e_cnt;
  logic          e_none;

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x = s;
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  // Behavioural reference: scan from the most significant bit.
  task automatic model(input logic [N-1:0] v);
    int lead = -1;
    for (int p = 0; p < N; p++) if (lead < 0 && v[N-1-p]) lead = p;
    e_none = (lead < 0);
    e_cnt  = (lead < 0) ? '0 : CW'(lead);
    e_hot  = '0;
    e_therm = '0;
    if (lead >= 0) begin
      e_hot[N-1-lead] = 1'b1;
      for (int p = 0; p < N; p++) if (p >= lead) e_therm[N-1-p] = 1'b1;
    end
  endtask

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h input=%h", req, act, exp, ind);
    end
  endtask

  // Drive after a rising edge, compare at the following falling edge.
  task automatic apply(input logic [N-1:0] v, input string req);
    @(posedge clk); #1 ind = v;
    @(negedge clk);
    model(v);
    chk({req, " R3 therm"}, therm, e_therm);
    chk({req, " R4 onehot"}, hot, e_hot);
    chk({req, " R5 count"}, N'(shamt), N'(e_cnt));
    chk({req, " R9 flag"}, N'(none), N'(e_none));
  endtask

  // R6: each count bit against an OR over one-hot groups, indexed by position.
  task automatic group_check();
    for (int b = 0; b < CW; b++) begin
      logic acc = 1'b0;
      for (int p = 0; p < N; p++) if (((p >> b) & 1) == 1) acc |= hot[N-1-p];
      chk("R6 count group", N'(shamt[b]), N'(acc));
    end
  endtask

  initial begin
    ind = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // R7 reset state / all-zero input
    apply('0, "R7 zero");
    chk("R7 zero flag", N'(none), N'(1'b1));
    // R2 position 0 is bit N-1
    apply({1'b1, {(N-1){1'b0}}}, "R2 msb");
    chk("R2 count at msb", N'(shamt), '0);
    apply({{(N-1){1'b0}}, 1'b1}, "R2 lsb");
    chk("R2 count at lsb", N'(shamt), N'(N-1));
    apply('1, "R4 all ones");
    // walking single bits
    for (int p = 0; p < N; p++) begin
      apply(N'(1) << (N-1-p), "R5 walk");
      group_check();
    end
    // R8 lower bits with noise; output must match for clean and noisy forms
    for (int p = 0; p < N; p++) begin
      logic [N-1:0] lead_bit = N'(1) << (N-1-p);
      logic [N-1:0] clean_hot, clean_therm;
      logic [CW-1:0] clean_cnt;
      apply(lead_bit, "R8 clean");
      clean_hot = hot; clean_therm = therm; clean_cnt = shamt;
      for (int k = 0; k < 3; k++) begin
        rng = nxt(rng);
        apply(lead_bit | (N'(rng) & (lead_bit - 1'b1)), "R8 noisy");
        chk("R8 hot unchanged", hot, clean_hot);
        chk("R8 therm unchanged", therm, clean_therm);
        chk("R8 count unchanged", N'(shamt), N'(clean_cnt));
        group_check();
      end
    end
    // random patterns, compared every clock
    for (int k = 0; k < 200; k++) begin
      rng = nxt(rng);
      apply(N'(rng) >> (rng[4:0]), "R4 random");
      group_check();
    end
    apply('0, "R7 zero again");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule